// File: doc/BRIEF.md
# Write-Phase Sequencer for an Asynchronous Handshake Bus

This block is a bus master that runs the write half of an indivisible read-modify-write transfer on a bus where the slave answers through an asynchronous handshake. The read half has already placed the address and function code on the bus and asserted the address strobe. A one-cycle start pulse hands the transfer to this block. The block holds the address, function code, address strobe and read direction. It then lowers the read/write line, drives the write data and raises the byte strobes. It waits for the slave to respond and afterwards releases the bus.

Each clock cycle of `clk` is one half-period of the bus clock, so every bus state lasts exactly one `clk` cycle. There are eight fixed states. The slave's acknowledge, bus-error and synchronous-peripheral request each pass through a two-stage synchronizer. They are looked at only on the edge that closes the strobe state and on the edge that closes each wait state. Wait states are inserted in pairs of half-states, which is one whole bus clock each, so that every later action keeps its bus-clock phase. Signal polarities at the ports are active high, except `rw_o`, where 1 means read and 0 means write.

Top module: `wrseq_top`

## Requirements
- R1: After reset, `as_o`, `uds_o`, `lds_o`, `addr_oe_o`, `data_oe_o`, `done_o`, `err_o` and `periph_o` are 0 and `rw_o` is 1.
- R2: A start pulse in idle latches `addr_i`, `fc_i`, `wdata_i` and `be_i`. From the following edge until release, `as_o=1`, `addr_oe_o=1` and `bus_addr_o`/`bus_fc_o` hold the latched values. Later changes on those inputs have no effect.
- R3: `rw_o` stays 1 for the first two states and goes to 0 on the second edge after the start edge.
- R4: `data_oe_o` goes to 1 on the third edge after the start edge, with `bus_data_o` equal to the latched write data.
- R5: On the fourth edge after the start edge, `uds_o` takes `be_i[1]` and `lds_o` takes `be_i[0]`. Both hold through any wait states until release.
- R6: Responses pass a two-flop synchronizer and are sampled on the fifth edge after start (close of the strobe state), then every second edge while waiting. A response high at edge k is first usable at edge k+2. With no wait, `done_o` pulses on the eighth edge, and each wait adds two cycles.
- R7: A sampled bus error ends the transfer through the normal release and sets `err_o`, which holds until the next start. If acknowledge and bus error are sampled together, the bus error wins.
- R8: A synchronous-peripheral request sampled at the close of the strobe state, with no acknowledge or error, sets `periph_o` and ends through the normal release without error. The same request seen only during wait states is ignored.
- R9: On the edge that is two edges after the terminating sample, `as_o`, `uds_o` and `lds_o` drop, while `rw_o` stays 0 and both buses stay driven. On the next edge, both output enables drop, `rw_o` returns to 1 and `done_o` is high for exactly one cycle.
- R10: A start pulse while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bus-clock rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin write phase (one cycle) |
| addr_i | input | AW | Address held from the read half |
| fc_i | input | 3 | Function code held from the read half |
| wdata_i | input | DW | Data to write |
| be_i | input | 2 | Byte enables: [1] upper, [0] lower |
| ack_i | input | 1 | Asynchronous data acknowledge from slave |
| berr_i | input | 1 | Asynchronous bus error |
| pirq_i | input | 1 | Asynchronous synchronous-peripheral request |
| bus_addr_o | output | AW | Address bus value |
| bus_fc_o | output | 3 | Function code value |
| addr_oe_o | output | 1 | Address/function code drive enable |
| bus_data_o | output | DW | Data bus value |
| data_oe_o | output | 1 | Data bus drive enable |
| as_o | output | 1 | Address strobe |
| uds_o | output | 1 | Upper data strobe |
| lds_o | output | 1 | Lower data strobe |
| rw_o | output | 1 | 1 read, 0 write |
| done_o | output | 1 | One-cycle pulse at release |
| err_o | output | 1 | Bus error seen, held until next start |
| periph_o | output | 1 | Transfer handed to a peripheral cycle |

## Verification
The bench varies when the acknowledge arrives across the synchronizer window. A design that skipped a synchronizer stage, sampled on the wrong edge, or inserted single half-cycle waits would finish a different number of cycles after start. It drives acknowledge and bus error together, and a late bus error after waits, to catch an inverted priority or an error flag that fails to hold or fails to clear on the next start. It also checks the ordering around release, where strobes must fall one cycle before direction and drive enables, and checks that a late peripheral request, a mid-transfer start pulse and changed address inputs leave the transfer untouched.

// File: rtl/wrseq_pkg.sv
package wrseq_pkg;
  localparam int FCW  = 3;
  localparam int NRSP = 3; // responses: [2] pirq, [1] berr, [0] ack

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,   // first write state: bus held from read half
    ST_QUIET,  // second state: nothing changes
    ST_DIR,    // third: direction to write
    ST_DRIVE,  // fourth: data driven
    ST_STRB,   // fifth: strobes, response sampled at its close
    ST_WAITA,  // wait, first half
    ST_WAITB,  // wait, second half, sample at close
    ST_POST1,
    ST_POST2,
    ST_FINAL
  } wr_state_t;
endpackage

// File: rtl/wrseq_sync.sv
module wrseq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wrseq_fsm.sv
module wrseq_fsm
  import wrseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [FCW-1:0]  fc_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [1:0]      be_i,
  input  logic [NRSP-1:0] rsp_s,
  output logic [AW-1:0]   bus_addr_o,
  output logic [FCW-1:0]  bus_fc_o,
  output logic            addr_oe_o,
  output logic [DW-1:0]   bus_data_o,
  output logic            data_oe_o,
  output logic            as_o,
  output logic            uds_o,
  output logic            lds_o,
  output logic            rw_o,
  output logic            done_o,
  output logic            err_o,
  output logic            periph_o
);
  wr_state_t st;
  logic [1:0] be_q;
  logic ack_s, berr_s, pirq_s;

  assign ack_s  = rsp_s[0];
  assign berr_s = rsp_s[1];
  assign pirq_s = rsp_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      bus_addr_o <= '0;
      bus_fc_o   <= '0;
      bus_data_o <= '0;
      be_q       <= '0;
      addr_oe_o  <= 1'b0;
      data_oe_o  <= 1'b0;
      as_o       <= 1'b0;
      uds_o      <= 1'b0;
      lds_o      <= 1'b0;
      rw_o       <= 1'b1;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      periph_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          bus_addr_o <= addr_i;
          bus_fc_o   <= fc_i;
          bus_data_o <= wdata_i;
          be_q       <= be_i;
          addr_oe_o  <= 1'b1;
          as_o       <= 1'b1;
          rw_o       <= 1'b1;
          err_o      <= 1'b0;
          periph_o   <= 1'b0;
          st         <= ST_HOLD;
        end
        ST_HOLD:  st <= ST_QUIET;
        ST_QUIET: begin
          rw_o <= 1'b0;
          st   <= ST_DIR;
        end
        ST_DIR: begin
          data_oe_o <= 1'b1;
          st        <= ST_DRIVE;
        end
        ST_DRIVE: begin
          uds_o <= be_q[1];
          lds_o <= be_q[0];
          st    <= ST_STRB;
        end
        ST_STRB: begin
          if (berr_s) begin
            err_o <= 1'b1;
            st    <= ST_POST1;
          end else if (ack_s) begin
            st <= ST_POST1;
          end else if (pirq_s) begin
            periph_o <= 1'b1;
            st       <= ST_POST1;
          end else begin
            st <= ST_WAITA;
          end
        end
        ST_WAITA: st <= ST_WAITB;
        ST_WAITB: begin
          if (berr_s) begin
            err_o <= 1'b1;
            st    <= ST_POST1;
          end else if (ack_s) begin
            st <= ST_POST1;
          end else begin
            st <= ST_WAITA;
          end
        end
        ST_POST1: st <= ST_POST2;
        ST_POST2: begin
          as_o  <= 1'b0;
          uds_o <= 1'b0;
          lds_o <= 1'b0;
          st    <= ST_FINAL;
        end
        ST_FINAL: begin
          addr_oe_o <= 1'b0;
          data_oe_o <= 1'b0;
          rw_o      <= 1'b1;
          done_o    <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: data strobes only inside an address strobe
  a_r5_strobe_in_as: assert property (@(posedge clk) disable iff (rst)
    (uds_o || lds_o) |-> as_o);

  // R3: write direction only while the address phase is held
  a_r3_write_needs_as: assert property (@(posedge clk) disable iff (rst)
    !rw_o |-> (addr_oe_o && st != ST_IDLE));

  // R4: data is driven only after direction turned to write
  a_r4_data_after_dir: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe_o) |-> (!rw_o && $past(!rw_o)));

  // R2: address held steady while strobe stays asserted
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (as_o && $past(as_o)) |-> ($stable(bus_addr_o) && $stable(bus_fc_o)));

  // R9: done marks a fully released bus, one cycle wide
  a_r9_done_released: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!as_o && rw_o && !addr_oe_o && !data_oe_o));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7/R8: a transfer ends with at most one outcome flag
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(err_o && periph_o));
endmodule

// File: rtl/wrseq_top.sv
module wrseq_top
  import wrseq_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    fc_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    be_i,
  input  logic          ack_i,
  input  logic          berr_i,
  input  logic          pirq_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [2:0]    bus_fc_o,
  output logic          addr_oe_o,
  output logic [DW-1:0] bus_data_o,
  output logic          data_oe_o,
  output logic          as_o,
  output logic          uds_o,
  output logic          lds_o,
  output logic          rw_o,
  output logic          done_o,
  output logic          err_o,
  output logic          periph_o
);
  logic [NRSP-1:0] rsp_s;

  wrseq_sync #(.W(NRSP), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({pirq_i, berr_i, ack_i}),
    .q_o (rsp_s)
  );

  wrseq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .fc_i       (fc_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .rsp_s      (rsp_s),
    .bus_addr_o (bus_addr_o),
    .bus_fc_o   (bus_fc_o),
    .addr_oe_o  (addr_oe_o),
    .bus_data_o (bus_data_o),
    .data_oe_o  (data_oe_o),
    .as_o       (as_o),
    .uds_o      (uds_o),
    .lds_o      (lds_o),
    .rw_o       (rw_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .periph_o   (periph_o)
  );
endmodule

// File: tb/wrseq_top_tb.sv
module wrseq_top_tb;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NV = 10;
  localparam int NEVER = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [2:0] fc_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [1:0] be_i = '0;
  logic ack_i = 1'b0, berr_i = 1'b0, pirq_i = 1'b0;
  logic [AW-1:0] bus_addr_o;
  logic [2:0] bus_fc_o;
  logic addr_oe_o, data_oe_o, as_o, uds_o, lds_o, rw_o, done_o, err_o, periph_o;
  logic [DW-1:0] bus_data_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wrseq_top #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .fc_i(fc_i),
    .wdata_i(wdata_i), .be_i(be_i), .ack_i(ack_i), .berr_i(berr_i),
    .pirq_i(pirq_i), .bus_addr_o(bus_addr_o), .bus_fc_o(bus_fc_o),
    .addr_oe_o(addr_oe_o), .bus_data_o(bus_data_o), .data_oe_o(data_oe_o),
    .as_o(as_o), .uds_o(uds_o), .lds_o(lds_o), .rw_o(rw_o), .done_o(done_o),
    .err_o(err_o), .periph_o(periph_o)
  );

  // vector: be, ack delay, berr delay, pirq delay, done latency, err, periph
  // a delay n means the input is first high at edge n after the start edge
  localparam logic [35:0] VEC [NV] = '{
    {2'b11, 8'd0,   8'd255, 8'd255, 8'd8,  1'b0, 1'b0},
    {2'b10, 8'd3,   8'd255, 8'd255, 8'd8,  1'b0, 1'b0},
    {2'b01, 8'd4,   8'd255, 8'd255, 8'd10, 1'b0, 1'b0},
    {2'b11, 8'd7,   8'd255, 8'd255, 8'd12, 1'b0, 1'b0},
    {2'b11, 8'd255, 8'd0,   8'd255, 8'd8,  1'b1, 1'b0},
    {2'b01, 8'd0,   8'd0,   8'd255, 8'd8,  1'b1, 1'b0},
    {2'b10, 8'd255, 8'd255, 8'd0,   8'd8,  1'b0, 1'b1},
    {2'b11, 8'd9,   8'd255, 8'd5,   8'd14, 1'b0, 1'b0},
    {2'b10, 8'd255, 8'd6,   8'd255, 8'd12, 1'b1, 1'b0},
    {2'b01, 8'd5,   8'd255, 8'd255, 8'd10, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run(input logic [35:0] v, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [2:0] f,
                     input logic poke_start);
    logic [1:0] be;
    int na, nb, np, lat;
    logic e_err, e_per, seen;
    be = v[35:34]; na = int'(v[33:26]); nb = int'(v[25:18]);
    np = int'(v[17:10]); lat = int'(v[9:2]); e_err = v[1]; e_per = v[0];
    seen = 1'b0;
    @(negedge clk);
    addr_i = a; wdata_i = d; fc_i = f; be_i = be; start_i = 1'b1;
    if (na == 0) ack_i = 1'b1;
    if (nb == 0) berr_i = 1'b1;
    if (np == 0) pirq_i = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 0) begin
        start_i = 1'b0;
        addr_i = ~a; wdata_i = ~d; fc_i = ~f; be_i = ~be;
      end
      if (poke_start && c == 3) start_i = 1'b1;
      if (poke_start && c == 4) start_i = 1'b0;
      if (c == 0) begin
        chk(as_o && addr_oe_o && rw_o, "R2 strobe/enable after start", {as_o, addr_oe_o, rw_o}, 3'b111);
        chk(bus_addr_o == a && bus_fc_o == f, "R2 address latched", bus_addr_o, a);
        chk(rw_o == 1'b1, "R3 read direction in first state", rw_o, 1);
      end
      if (c == 1) chk(rw_o == 1'b1 && !data_oe_o, "R3 rw held high second state", rw_o, 1);
      if (c == 2) chk(rw_o == 1'b0 && !data_oe_o && !uds_o && !lds_o, "R3 rw low at third state", {rw_o, data_oe_o}, 2'b00);
      if (c == 3) chk(data_oe_o && bus_data_o == d && !uds_o && !lds_o, "R4 data driven", bus_data_o, d);
      if (c == 4) chk({uds_o, lds_o} == be, "R5 strobes from byte enables", {uds_o, lds_o}, be);
      if (c == lat - 2) chk({uds_o, lds_o} == be && as_o, "R5 strobes held until release", {as_o, uds_o, lds_o}, {1'b1, be});
      if (c == lat - 1) chk(!as_o && !uds_o && !lds_o && !rw_o && addr_oe_o && data_oe_o,
                            "R9 strobes drop before direction", {as_o, uds_o, lds_o, rw_o, addr_oe_o, data_oe_o}, 6'b000011);
      if (na != NEVER && c == na - 1) ack_i = 1'b1;
      if (nb != NEVER && c == nb - 1) berr_i = 1'b1;
      if (np != NEVER && c == np - 1) pirq_i = 1'b1;
      if (done_o) begin
        seen = 1'b1;
        chk(c == lat, "R6 done latency", c, lat);
        chk(err_o == e_err, "R7 error flag", err_o, e_err);
        chk(periph_o == e_per, "R8 peripheral flag", periph_o, e_per);
        chk(!as_o && rw_o && !addr_oe_o && !data_oe_o, "R9 bus released", {as_o, rw_o, addr_oe_o, data_oe_o}, 4'b0100);
        chk(bus_addr_o == a, "R2 address unchanged by input edits", bus_addr_o, a);
        break;
      end
    end
    if (!seen) chk(1'b0, "R6 done never seen", 0, lat);
    ack_i = 1'b0; berr_i = 1'b0; pirq_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle wide", done_o, 0);
    chk(err_o == e_err && periph_o == e_per, "R7 flags held after done", {err_o, periph_o}, {e_err, e_per});
    if (poke_start) chk(!as_o && !addr_oe_o, "R10 start while busy ignored", {as_o, addr_oe_o}, 2'b00);
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!as_o && !uds_o && !lds_o && !addr_oe_o && !data_oe_o && rw_o && !done_o && !err_o && !periph_o,
        "R1 reset state", {as_o, uds_o, lds_o, addr_oe_o, data_oe_o, rw_o, done_o, err_o, periph_o}, 9'b000001000);
    for (int i = 0; i < NV; i++)
      run(VEC[i], 24'h10_0000 + 24'(i * 24'h1357), 16'hA500 ^ 16'(i * 16'h0111), 3'(i + 1), 1'b0);
    // R10: extra start pulse mid transfer
    run({2'b11, 8'd0, 8'd255, 8'd255, 8'd8, 1'b0, 1'b0}, 24'hABCDEF, 16'h5A5A, 3'd5, 1'b1);
    // R7: error clears on the next start
    run({2'b11, 8'd255, 8'd2, 8'd255, 8'd8, 1'b1, 1'b0}, 24'h000123, 16'h0F0F, 3'd6, 1'b0);
    run({2'b01, 8'd1, 8'd255, 8'd255, 8'd8, 1'b0, 1'b0}, 24'h000456, 16'hF0F0, 3'd2, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule